// File: doc/BRIEF.md
# Commutation Clock Generator

This block schedules the phase changes of a three-phase spindle motor that has no position sensors. Its only view of the rotor is a speed feedback pulse, FG, which toggles at every back-EMF zero crossing. The block cleans FG of short glitches and measures the interval between accepted FG transitions with a tick counter. It then fires a one-cycle commutation strobe after a delay taken from that interval. After each strobe it holds a blanking window, so that the coil switching spike is not read as the next zero crossing.

Three operating phases are selected on `mode_i`:

- **Start-up:** the rotor position is unknown, so the strobe is free-running at a fixed rate.
- **Acceleration (hard commutation):** the delay and the blanking length are fixed fractions of the interval just measured.
- **Running (soft commutation):** the delay is a much smaller fraction of the interval, and the blanking length is a fixed constant.

A retry request tells the controller to restart the spin-up sequence. It is raised when the rotor stalls, or when FG shows the wrong polarity during start-up.

Top module: `comm_clk_gen`

## Requirements
- R1: While `rst_ni` is low, `mclk_o`, `mask_o` and `retry_o` are 0 and `period_o` is 0.
- R2: A change on `fg_i` that lasts fewer than FILT_LEN clock samples is dropped. It starts no measurement and no strobe, and `period_o` keeps its value.
- R3: With `mode_i` = 2'b00 (start-up), `mclk_o` pulses every START_DLY ticks. Each pulse opens a blanking window of START_MASK ticks, and `mask_o` is high from the strobe cycle onward.
- R4: With `mode_i` = 2'b01 (acceleration), a good FG edge schedules the strobe after D = P >> 1 ticks, where P is the interval that edge has just closed. With `tick_i` held high, `mclk_o` rises FILT_LEN+3+D clock cycles after `fg_i` changes, which puts the strobe 30 electrical degrees after the zero crossing.
- R5: In acceleration, the blanking window after each strobe lasts P >> 2 ticks, counted from the strobe cycle.
- R6: With `mode_i[1]` = 1 (running), the delay is P >> 5 ticks, measured the same way as in R4, and the blanking window is RUN_MASK ticks.
- R7: At each good FG edge, `period_o` takes the number of ticks since the previous good edge. It changes at no other time.
- R8: An FG edge whose filtered transition falls while `mask_o` is high is ignored. It produces no strobe and leaves `period_o` unchanged.
- R9: An accepted FG edge whose new level equals the level of the last accepted edge is a polarity mismatch. It produces no strobe and leaves `period_o` unchanged. In start-up it raises `retry_o` for one cycle; in the other modes it raises nothing.
- R10: If no good edge arrives for 2^PERIOD_W-1 ticks, the count saturates and `retry_o` pulses once. The next good edge stores the saturated value in `period_o`.
- R11: A good edge that arrives while a strobe is still pending cancels that strobe and schedules a new one from its own interval.
- R12: `mclk_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe (1 us in use) |
| fg_i | input | 1 | Raw speed feedback pulse |
| mode_i | input | 2 | 00 start-up, 01 acceleration, 1x running |
| mclk_o | output | 1 | Commutation strobe, one cycle |
| mask_o | output | 1 | Blanking window active |
| period_o | output | PERIOD_W | Last measured FG interval in ticks |
| retry_o | output | 1 | Start-up retry request pulse |

## Verification
The bench builds the block with the following parameter values:

| Parameter | Bench value |
|---|---|
| PERIOD_W | 10 |
| FILT_LEN | 3 |
| START_DLY | 40 |
| START_MASK | 20 |
| RUN_MASK | 7 |

It also holds `tick_i` high, so one tick equals one clock. With these values the stall limit is 1023 cycles, which puts counter saturation and its single retry pulse within a short run. The small start-up constants let the free-running strobe and blanking window repeat several times. The narrow filter makes a two-cycle glitch a real boundary case. Every delay fraction and blanking length can then be checked to the exact cycle, including the cancel-and-reload and the masked-then-mismatched edge sequences.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  typedef enum logic [1:0] {
    MODE_START = 2'b00,
    MODE_ACCEL = 2'b01,
    MODE_RUN   = 2'b10,
    MODE_RUN2  = 2'b11
  } mode_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/ccg_fg_filter.sv
module ccg_fg_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fg_i,
  output logic edge_o,
  output logic level_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q, lvl_q;
  logic [CW-1:0] cnt_q;
  logic          hit;

  // new level must persist for FILT_LEN samples
  assign hit = (s2_q != lvl_q) && (cnt_q == CW'(FILT_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= fg_i;
      s2_q <= s1_q;
      if (s2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (hit) begin
        lvl_q <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign edge_o  = hit;
  assign level_o = s2_q;
endmodule

// File: rtl/ccg_period_meter.sv
module ccg_period_meter #(
  parameter int unsigned PW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  output logic [PW-1:0] meas_o,
  output logic [PW-1:0] period_o,
  output logic          stall_o,
  output logic          sat_o
);
  localparam logic [PW-1:0] MAXV = {PW{1'b1}};

  logic [PW-1:0] cnt_q, period_q;
  logic          inc;

  assign sat_o  = (cnt_q == MAXV);
  assign inc    = tick_i && !sat_o;
  assign meas_o = inc ? cnt_q + 1'b1 : cnt_q;
  // one pulse on entry into saturation
  assign stall_o = inc && (cnt_q == MAXV - 1'b1) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= '0;
    end else if (restart_i) begin
      period_q <= meas_o;
      cnt_q    <= '0;
    end else begin
      cnt_q <= meas_o;
    end
  end

  assign period_o = period_q;
endmodule

// File: rtl/ccg_commut_timer.sv
module ccg_commut_timer
  import ccg_pkg::*;
#(
  parameter int unsigned PW          = 20,
  parameter int unsigned START_DLY   = 2000,
  parameter int unsigned START_MASK  = 1000,
  parameter int unsigned RUN_MASK    = 344,
  parameter int unsigned ACC_DLY_SH  = 1,
  parameter int unsigned ACC_MASK_SH = 2,
  parameter int unsigned RUN_DLY_SH  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  mode_e         mode_i,
  input  logic          load_i,
  input  logic [PW-1:0] meas_i,
  output logic          mclk_o,
  output logic          mask_o
);
  localparam int unsigned MW = max3(PW, $clog2(START_MASK + 1), $clog2(RUN_MASK + 1));
  localparam int unsigned SW = $clog2(START_DLY + 1);

  logic          is_start, is_acc;
  logic          pend_q, mclk_q;
  logic [PW-1:0] dly_q, dly_ld;
  logic [MW-1:0] mlen_q, msk_q, msk_ld;
  logic [SW-1:0] st_q;
  logic          st_fire, dly_fire;

  assign is_start = (mode_i == MODE_START);
  assign is_acc   = (mode_i == MODE_ACCEL);
  assign dly_ld   = is_acc ? PW'(meas_i >> ACC_DLY_SH) : PW'(meas_i >> RUN_DLY_SH);
  assign msk_ld   = is_acc ? MW'(meas_i >> ACC_MASK_SH) : MW'(RUN_MASK);

  assign st_fire  = is_start && tick_i && (st_q == SW'(START_DLY - 1));
  assign dly_fire = !is_start && pend_q && !load_i && tick_i && (dly_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q <= 1'b0;
      st_q   <= '0;
      pend_q <= 1'b0;
      dly_q  <= '0;
      mlen_q <= '0;
      msk_q  <= '0;
    end else begin
      mclk_q <= st_fire || dly_fire;

      if (!is_start)   st_q <= '0;
      else if (tick_i) st_q <= st_fire ? '0 : st_q + 1'b1;

      // a fresh edge overrides any pending strobe
      if (is_start) begin
        pend_q <= 1'b0;
      end else if (load_i) begin
        pend_q <= 1'b1;
        dly_q  <= dly_ld;
        mlen_q <= msk_ld;
      end else if (pend_q && tick_i) begin
        if (dly_q == '0) pend_q <= 1'b0;
        else             dly_q  <= dly_q - 1'b1;
      end

      if (st_fire)                   msk_q <= MW'(START_MASK);
      else if (dly_fire)             msk_q <= mlen_q;
      else if (tick_i && msk_q != 0) msk_q <= msk_q - 1'b1;
    end
  end

  assign mclk_o = mclk_q;
  assign mask_o = (msk_q != '0);
endmodule

// File: rtl/comm_clk_gen.sv
module comm_clk_gen
  import ccg_pkg::*;
#(
  parameter int unsigned PERIOD_W    = 20,
  parameter int unsigned FILT_LEN    = 4,
  parameter int unsigned START_DLY   = 2000,
  parameter int unsigned START_MASK  = 1000,
  parameter int unsigned RUN_MASK    = 344,
  parameter int unsigned ACC_DLY_SH  = 1,
  parameter int unsigned ACC_MASK_SH = 2,
  parameter int unsigned RUN_DLY_SH  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                fg_i,
  input  logic [1:0]          mode_i,
  output logic                mclk_o,
  output logic                mask_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                retry_o
);
  mode_e                mode;
  logic                 edge_w, lvl_w, mask_w;
  logic                 acc_edge, good_edge, mism;
  logic                 stall_w, sat_w;
  logic [PERIOD_W-1:0]  meas_w;
  logic                 last_pol_q, retry_q;

  assign mode = mode_e'(mode_i);

  ccg_fg_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fg_i    (fg_i),
    .edge_o  (edge_w),
    .level_o (lvl_w)
  );

  assign acc_edge  = edge_w && !mask_w;
  assign good_edge = acc_edge && (lvl_w != last_pol_q);
  assign mism      = acc_edge && (lvl_w == last_pol_q);

  ccg_period_meter #(.PW(PERIOD_W)) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (good_edge),
    .meas_o    (meas_w),
    .period_o  (period_o),
    .stall_o   (stall_w),
    .sat_o     (sat_w)
  );

  ccg_commut_timer #(
    .PW          (PERIOD_W),
    .START_DLY   (START_DLY),
    .START_MASK  (START_MASK),
    .RUN_MASK    (RUN_MASK),
    .ACC_DLY_SH  (ACC_DLY_SH),
    .ACC_MASK_SH (ACC_MASK_SH),
    .RUN_DLY_SH  (RUN_DLY_SH)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .mode_i (mode),
    .load_i (good_edge),
    .meas_i (meas_w),
    .mclk_o (mclk_o),
    .mask_o (mask_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_pol_q <= 1'b0;
      retry_q    <= 1'b0;
    end else begin
      if (acc_edge) last_pol_q <= lvl_w;
      retry_q <= (mism && mode == MODE_START) || stall_w;
    end
  end

  assign mask_o  = mask_w;
  assign retry_o = retry_q;
endmodule

// File: rtl/comm_clk_gen_chk.sv
module comm_clk_gen_chk #(
  parameter int unsigned PW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          mclk_o,
  input logic          mask_o,
  input logic          retry_o,
  input logic [PW-1:0] period_o,
  input logic          good_edge_i,
  input logic          edge_i,
  input logic          sat_i
);
  // R12
  a_r12_mclk_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_o |=> !mclk_o);

  // R7
  a_r7_period_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(period_o) |-> $past(good_edge_i));

  // R8
  a_r8_masked_edge_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && mask_o) |=> $stable(period_o));

  // R3
  a_r3_start_mask_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mclk_o && $past(mode_i) == 2'b00) |-> mask_o);

  // R9, R10
  a_r9_retry_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> ($past(mode_i) == 2'b00) || sat_i);
endmodule

bind comm_clk_gen comm_clk_gen_chk #(.PW(PERIOD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .mclk_o      (mclk_o),
  .mask_o      (mask_o),
  .retry_o     (retry_o),
  .period_o    (period_o),
  .good_edge_i (good_edge),
  .edge_i      (edge_w),
  .sat_i       (sat_w)
);

// File: tb/comm_clk_gen_bench.sv
module comm_clk_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW    = 10;
  localparam int FILT  = 3;
  localparam int SDLY  = 40;
  localparam int SMASK = 20;
  localparam int RMASK = 7;
  localparam int LAT   = FILT + 3;
  localparam int MAXP  = (1 << PW) - 1;

  // mode, interval, expected delay, expected blanking
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{1,  48, 24, 12},
    '{1, 100, 50, 25},
    '{1, 150, 75, 37},
    '{2,  48,  1,  7},
    '{2, 100,  3,  7},
    '{2, 200,  6,  7}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic          fg = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          mclk, mask, retry;
  logic [PW-1:0] period;
  int            cyc = 0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD / 2) clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  comm_clk_gen #(
    .PERIOD_W(PW), .FILT_LEN(FILT), .START_DLY(SDLY),
    .START_MASK(SMASK), .RUN_MASK(RMASK)
  ) u_comm_clk_gen (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .fg_i(fg), .mode_i(mode),
    .mclk_o(mclk), .mask_o(mask), .period_o(period), .retry_o(retry)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_mclk(input int limit, output int m, output bit found);
    found = 1'b0;
    m = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (mclk) begin
        m = cyc;
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic count_mask(output int n);
    n = 0;
    while (mask && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic preroll(input int t);
    mode = 2'b10;
    fg = !fg;
    cycles(t);
    fg = !fg;
    cycles(t);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int m1, m2, m3, n, nm, cnt, p0;
    bit f;
    // R1 reset state
    cycles(3);
    chk(mclk == 1'b0, "R1 mclk", mclk, 0);
    chk(mask == 1'b0, "R1 mask", mask, 0);
    chk(retry == 1'b0, "R1 retry", retry, 0);
    chk(period == '0, "R1 period", period, 0);
    rst_n = 1'b1;

    // R3 start-up interval and blanking
    wait_mclk(200, m1, f);
    wait_mclk(200, m2, f);
    chk(f && (m2 - m1 == SDLY), "R3 interval", m2 - m1, SDLY);
    count_mask(cnt);
    chk(cnt == SMASK, "R3 blanking", cnt, SMASK);

    // R9 start-up: masked edge, then mismatched edge raises retry
    wait_mclk(200, m3, f);
    cycles(4);
    fg = 1'b1;
    cycles(21);
    fg = 1'b0;
    cnt = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (retry) cnt++;
    end
    chk(cnt == 1, "R9 start-up retry", cnt, 1);

    // R4 R5 R6 R7 vector table
    for (int v = 0; v < NVEC; v++) begin
      preroll(VEC[v][1]);
      mode = VEC[v][0][1:0];
      fg = !fg;
      n = cyc;
      wait_mclk(VEC[v][1] + LAT + 50, nm, f);
      chk(f && (nm - n == LAT + VEC[v][2]), VEC[v][0] == 1 ? "R4 delay" : "R6 delay",
          nm - n, LAT + VEC[v][2]);
      count_mask(cnt);
      chk(cnt == VEC[v][3], VEC[v][0] == 1 ? "R5 blanking" : "R6 blanking", cnt, VEC[v][3]);
      while (cyc < n + VEC[v][1]) @(negedge clk);
      chk(period == PW'(VEC[v][1]), "R7 period", period, VEC[v][1]);
    end

    // R2 two-sample glitch
    p0 = period;
    fg = !fg;
    cycles(2);
    fg = !fg;
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mclk) cnt++;
    end
    chk(cnt == 0, "R2 glitch strobe", cnt, 0);
    chk(period == PW'(p0), "R2 glitch period", period, p0);

    // R11 cancel and reload
    preroll(40);
    mode = 2'b01;
    fg = !fg;
    cycles(10);
    fg = !fg;
    n = cyc;
    cnt = 0;
    m1 = -1;
    for (int i = 0; i < LAT + 40; i++) begin
      @(negedge clk);
      if (mclk) begin
        cnt++;
        if (m1 < 0) m1 = cyc;
      end
    end
    chk(cnt == 1, "R11 single strobe", cnt, 1);
    chk(m1 - n == LAT + 5, "R11 reload delay", m1 - n, LAT + 5);

    // R8 edge inside blanking
    preroll(64);
    mode = 2'b01;
    fg = !fg;
    wait_mclk(200, m1, f);
    cycles(4);
    fg = !fg;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mclk) cnt++;
    end
    chk(cnt == 0, "R8 masked strobe", cnt, 0);
    chk(period == PW'(64), "R8 masked period", period, 64);

    // R9 mismatch outside start-up
    fg = !fg;
    cnt = 0;
    nm = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mclk) cnt++;
      if (retry) nm++;
    end
    chk(cnt == 0, "R9 mismatch strobe", cnt, 0);
    chk(nm == 0, "R9 mismatch retry", nm, 0);
    chk(period == PW'(64), "R9 mismatch period", period, 64);

    // R10 stall
    cnt = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (retry) cnt++;
    end
    chk(cnt == 1, "R10 stall retry", cnt, 1);
    fg = !fg;
    cycles(20);
    chk(period == PW'(MAXP), "R10 saturated period", period, MAXP);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule